// File: doc/BRIEF.md
# Page-Buffered Write Sequencer with Polling Status

This block is a synchronous write controller for a byte-wide memory array with an SRAM-like interface. A host writes bytes with a write strobe, a 19-bit address and 8-bit data. The upper address bits select a page and the lower seven bits select one of 128 byte slots. The first write opens a page. Later writes to the same page fill more slots in any order, and a slot written again keeps the newest value. Each filled slot is flagged. Once no byte has arrived for a set number of clock cycles, the block stops loading and starts a programming period of fixed length. At the end of that period it commits only the flagged slots into the backing array.

While programming is in progress the block reports busy. Reads do not return stored data; they return polling status. Bit 7 carries the complement of bit 7 of the last byte accepted. Bit 6 alternates on every read. Bits 5:0 carry the last byte's true low bits. After the period ends, a one-cycle done pulse is raised, reads return the true array contents, and a new page may be started. The backing array is modelled as a register array that holds `MEM_PAGES` pages. Page numbers are folded onto the low page-address bits.

Top module: `page_prog_seq`

## Requirements
- R1: After reset, `busy` and `prog_done` are 0, `rd_data` is 0x00, and every array byte reads as 0xFF.
- R2: A write accepted while idle opens the page given by address bits 18:7 and stores the data in slot address[6:0].
- R3: Further writes to the open page may come in any slot order. A slot written more than once commits the last value written to it.
- R4: While a page is loading, a write whose address bits 18:7 differ from the open page is ignored. Its byte is never committed.
- R5: `busy` rises exactly `LOAD_GAP` clock edges after the edge that accepted the last byte, provided no further byte was accepted in between.
- R6: Only flagged slots are written to the array. Every other byte of that page, and of every other page, keeps its value.
- R7: While `busy` is high, a read at any address returns {~L[7], T, L[5:0]}, where L is the last accepted byte and T is the toggle bit.
- R8: The toggle bit T is 0 on the first read after `busy` rises and inverts after each read made while busy.
- R9: `busy` stays high for exactly `PROG_CYCLES` cycles. `prog_done` is high for the single cycle after `busy` falls, and reads then return the committed data.
- R10: Writes presented while `busy` is high are ignored and change no array byte.
- R11: `rd_data` takes its new value on the clock edge that samples `rd_en` and holds that value while `rd_en` is low. During loading, reads return array contents, not pending buffer bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_addr | input | 19 | Write address: page in 18:7, slot in 6:0 |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 19 | Read address |
| rd_data | output | 8 | Registered read data or polling status |
| busy | output | 1 | Programming period in progress |
| prog_done | output | 1 | One-cycle pulse after programming ends |

## Verification
The bench checks the edge on which `busy` rises relative to the last accepted load. A timer that restarts on the wrong event, or counts one cycle too many, moves that edge. It checks that a rewritten slot commits its second value and that a neighbouring slot stays at 0xFF. A design that commits the whole buffer would overwrite that neighbour with stale contents. Stray writes to another page, and writes made while busy, are read back as still erased, so a design that accepts them is caught. The polling reads confirm that the first toggle value is 0 and that the value alternates afterwards. A toggle that is not cleared at the start of programming, or that flips on idle cycles, breaks that sequence.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } seq_state_t;

  // Status word shown while programming: inverted top bit, toggle, low bits.
  function automatic logic [BYTE_W-1:0] poll_word(input logic [BYTE_W-1:0] last,
                                                  input logic tog);
    poll_word = {~last[BYTE_W-1], tog, last[BYTE_W-3:0]};
  endfunction

  // True when two addresses select the same page.
  function automatic logic same_page(input logic [31:0] a, input logic [31:0] b);
    same_page = (a == b);
  endfunction
endpackage

// File: rtl/pgseq_interval.sv
module pgseq_interval #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (restart)
      cnt <= '0;
    else if (run && cnt != LAST)
      cnt <= cnt + 1'b1;
  end

  assign expire = run && !restart && (cnt == LAST);
endmodule

// File: rtl/pgseq_page_buf.sv
module pgseq_page_buf #(
  parameter int SLOTS = 128,
  parameter int DW    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [$clog2(SLOTS)-1:0]    slot,
  input  logic [DW-1:0]               din,
  input  logic                        clear,
  output logic [SLOTS-1:0][DW-1:0]    bytes,
  output logic [SLOTS-1:0]            flags
);
  localparam int SW = $clog2(SLOTS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (clear) begin
      flags <= '0;
    end else if (load) begin
      flags[slot] <= 1'b1;
    end
  end

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          bytes[g] <= '0;
        else if (load && slot == SW'(g))
          bytes[g] <= din;
      end
    end
  endgenerate

  // R3: a loaded slot holds the newest byte and is flagged
  assert_slot_loaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> (flags[$past(slot)] && bytes[$past(slot)] == $past(din)));
endmodule

// File: rtl/pgseq_store.sv
module pgseq_store #(
  parameter int SLOTS  = 128,
  parameter int PAGE_W = 3,
  parameter int DW     = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              commit,
  input  logic [PAGE_W-1:0]                 page,
  input  logic [SLOTS-1:0][DW-1:0]          bytes,
  input  logic [SLOTS-1:0]                  flags,
  input  logic [PAGE_W+$clog2(SLOTS)-1:0]   rd_idx,
  output logic [DW-1:0]                     rd_byte
);
  localparam int SW    = $clog2(SLOTS);
  localparam int DEPTH = SLOTS << PAGE_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (commit) begin
      for (int s = 0; s < SLOTS; s++)
        if (flags[s]) mem[{page, SW'(s)}] <= bytes[s];
    end
  end

  assign rd_byte = mem[rd_idx];
endmodule

// File: rtl/pgseq_poll.sv
module pgseq_poll
  import pgseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  input  logic              start,
  input  logic              rd,
  output logic              tog,
  output logic [BYTE_W-1:0] status
);
  logic [BYTE_W-1:0] last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last <= '0;
      tog  <= 1'b0;
    end else begin
      if (load) last <= din;
      if (start)   tog <= 1'b0;
      else if (rd) tog <= ~tog;
    end
  end

  assign status = poll_word(last, tog);

  // R8: the toggle inverts on each status read
  assert_tog_flips_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !start) |=> (tog != $past(tog)));
endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq
  import pgseq_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int SLOTS       = 128,
  parameter int MEM_PAGE_W  = 3,
  parameter int LOAD_GAP    = 18750,
  parameter int PROG_CYCLES = 625000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              prog_done
);
  localparam int SW     = $clog2(SLOTS);
  localparam int PAGE_W = ADDR_W - SW;
  localparam int IDX_W  = MEM_PAGE_W + SW;

  seq_state_t        state;
  logic [PAGE_W-1:0] cur_page;
  logic [PAGE_W-1:0] wr_page;
  logic              page_match;
  logic              load_accept;
  logic              gap_expire;
  logic              prog_expire;
  logic              enter_prog;
  logic [SLOTS-1:0][7:0] buf_bytes;
  logic [SLOTS-1:0]  buf_flags;
  logic [7:0]        store_byte;
  logic [7:0]        poll_status;
  logic              poll_tog;
  logic              status_rd;

  assign wr_page     = wr_addr[ADDR_W-1:SW];
  assign page_match  = same_page(32'(wr_page), 32'(cur_page));
  assign load_accept = wr_en && ((state == ST_IDLE) || (state == ST_LOAD && page_match));
  assign enter_prog  = (state == ST_LOAD) && gap_expire;
  assign busy        = (state == ST_PROG);
  assign status_rd   = rd_en && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_page  <= '0;
      prog_done <= 1'b0;
    end else begin
      prog_done <= prog_expire;
      case (state)
        ST_IDLE: if (load_accept) begin
          state    <= ST_LOAD;
          cur_page <= wr_page;
        end
        ST_LOAD: if (enter_prog) state <= ST_PROG;
        ST_PROG: if (prog_expire) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  pgseq_interval #(.LIMIT(LOAD_GAP)) u_gap (
    .clk(clk), .rst_n(rst_n),
    .run(state == ST_LOAD), .restart(load_accept),
    .expire(gap_expire)
  );

  pgseq_interval #(.LIMIT(PROG_CYCLES)) u_prog (
    .clk(clk), .rst_n(rst_n),
    .run(busy), .restart(enter_prog),
    .expire(prog_expire)
  );

  pgseq_page_buf #(.SLOTS(SLOTS), .DW(8)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .load(load_accept), .slot(wr_addr[SW-1:0]), .din(wr_data),
    .clear(prog_expire),
    .bytes(buf_bytes), .flags(buf_flags)
  );

  pgseq_store #(.SLOTS(SLOTS), .PAGE_W(MEM_PAGE_W), .DW(8)) u_store (
    .clk(clk), .rst_n(rst_n),
    .commit(prog_expire), .page(cur_page[MEM_PAGE_W-1:0]),
    .bytes(buf_bytes), .flags(buf_flags),
    .rd_idx(IDX_W'({rd_addr[SW+MEM_PAGE_W-1:SW], rd_addr[SW-1:0]})),
    .rd_byte(store_byte)
  );

  pgseq_poll u_poll (
    .clk(clk), .rst_n(rst_n),
    .load(load_accept), .din(wr_data),
    .start(enter_prog), .rd(status_rd),
    .tog(poll_tog), .status(poll_status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= busy ? poll_status : store_byte;
  end

  // R10: nothing is accepted while programming
  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load_accept);
  // R4: loads during a page operation stay on the open page
  assert_same_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_LOAD) && load_accept) |-> (wr_page == cur_page));
  // R9: done pulse directly follows the end of busy
  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |-> (!busy && $past(busy)));
  // R8: toggle starts at zero when programming starts
  assert_tog_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (poll_tog == 1'b0));
  // R5: gap expiry moves the block into programming
  assert_gap_starts_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
    enter_prog |=> busy);
endmodule

// File: tb/sim_page_prog_seq.sv
module sim_page_prog_seq;
  localparam int GAP  = 20;
  localparam int PROG = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [18:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic        busy;
  logic        prog_done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  page_prog_seq #(.LOAD_GAP(GAP), .PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .prog_done(prog_done)
  );

  function automatic logic [18:0] mk(input int page, input int slot);
    mk = 19'((page << 7) | slot);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [18:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * (GAP + PROG); i++) begin
      @(negedge clk);
      if (!busy && i > GAP + 2) break;
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 busy", 32'(busy), 0);
    check("R1 prog_done", 32'(prog_done), 0);
    check("R1 rd_data", 32'(rd_data), 0);
    do_read(mk(2, 5), d);
    check("R1 erased byte", 32'(d), 32'hFF);
    @(negedge clk);
    check("R11 hold", 32'(rd_data), 32'hFF);
  endtask

  task automatic t_timing();
    logic [7:0] d;
    do_write(mk(1, 9), 8'h3C);
    do_write(mk(1, 2), 8'h11);
    do_read(mk(1, 9), d);
    check("R11 pending not visible", 32'(d), 32'hFF);
    do_write(mk(1, 2), 8'h12);
    repeat (GAP - 1) @(negedge clk);
    check("R5 not yet busy", 32'(busy), 0);
    @(negedge clk);
    check("R5 busy rises", 32'(busy), 1);
    repeat (PROG - 1) @(negedge clk);
    check("R9 busy held", 32'(busy), 1);
    check("R9 no early done", 32'(prog_done), 0);
    @(negedge clk);
    check("R9 busy falls", 32'(busy), 0);
    check("R9 done pulse", 32'(prog_done), 1);
    @(negedge clk);
    check("R9 done single", 32'(prog_done), 0);
    do_read(mk(1, 9), d);
    check("R2 committed byte", 32'(d), 32'h3C);
    do_read(mk(1, 2), d);
    check("R3 last value wins", 32'(d), 32'h12);
    do_read(mk(1, 3), d);
    check("R6 unloaded slot", 32'(d), 32'hFF);
  endtask

  task automatic t_polling();
    logic [7:0] d;
    logic [7:0] last;
    last = 8'hA5;
    do_write(mk(3, 0), 8'h77);
    do_write(mk(3, 1), last);
    while (!busy) @(negedge clk);
    do_write(mk(4, 6), 8'h42);
    do_read(mk(3, 1), d);
    check("R7/R8 first status", 32'(d), 32'({~last[7], 1'b0, last[5:0]}));
    do_read(mk(3, 1), d);
    check("R8 second status", 32'(d), 32'({~last[7], 1'b1, last[5:0]}));
    do_read(mk(0, 0), d);
    check("R7 any address", 32'(d), 32'({~last[7], 1'b0, last[5:0]}));
    wait_idle();
    do_read(mk(3, 1), d);
    check("R9 true data after", 32'(d), 32'(last));
    do_read(mk(4, 6), d);
    check("R10 busy write dropped", 32'(d), 32'hFF);
  endtask

  task automatic t_wrong_page();
    logic [7:0] d;
    do_write(mk(5, 10), 8'h5A);
    do_write(mk(6, 11), 8'hC3);
    do_write(mk(5, 12), 8'h81);
    wait_idle();
    do_read(mk(6, 11), d);
    check("R4 other page ignored", 32'(d), 32'hFF);
    do_read(mk(5, 11), d);
    check("R4 slot not taken", 32'(d), 32'hFF);
    do_read(mk(5, 12), d);
    check("R2 page kept", 32'(d), 32'h81);
  endtask

  task automatic t_preserve();
    logic [7:0] d;
    do_write(mk(1, 3), 8'h9E);
    wait_idle();
    do_read(mk(1, 3), d);
    check("R6 new byte", 32'(d), 32'h9E);
    do_read(mk(1, 9), d);
    check("R6 old byte kept", 32'(d), 32'h3C);
    do_read(mk(1, 2), d);
    check("R6 old byte kept 2", 32'(d), 32'h12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timing();
    t_polling();
    t_wrong_page();
    t_preserve();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R9: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule